// File: doc/BRIEF.md
# Execute Stage with Condition Flags

This block is the execute stage of a 64-bit machine that completes one instruction per cycle. The current instruction's opcode picks the two ALU operands and the ALU operation. Operand A comes from the first register read, the immediate, a stack step constant of 4, or zero. Operand B comes from the second register read or zero. The ALU then produces a data-path result. Every operation is computed as B op A.

Three condition flags sit in registers: zero, sign and overflow. Only the register-to-register ALU instruction writes them. Every opcode evaluates a 4-bit condition code against the stored flags. Only the conditional-move and conditional-jump opcodes can see a false result; all other opcodes always get true. When a conditional move finds its condition false, the block drops the write-enable of the result register.

Top module: `exu_stage`

## Requirements
- R1: Operand A depends on the opcode. It is `val_a_i` for opcodes 2 and 6. It is `val_c_i` for opcodes 3, 4, 5 and 7. It is the constant 4 for opcodes 8, 9, A and B. It is 0 for every other opcode.
- R2: Operand B is `val_b_i` for opcodes 4, 5, 6, 8, 9, A and B, and 0 for every other opcode.
- R3: The operation also depends on the opcode. Opcode 6 uses `fn_i`. Opcodes 8 and A subtract, so `res_o` is `val_b_i - 4`. Every other opcode adds.
- R4: The operation codes are 0 add, 1 subtract, 2 and, 3 xor, 4 multiply, 5 unsigned divide and 6 unsigned remainder. Code 7 shifts left and code 8 shifts right logically. The shift distance is taken from the low 6 bits of operand A. Codes 9 to F give 0.
- R5: Overflow is set when the exact result does not fit in 64 unsigned bits. That covers an add carry, a subtract that goes below zero, and a product that reaches 2^64. And, xor and both shifts never set it.
- R6: Divide or remainder by zero gives a result of all ones with overflow set.
- R7: Zero is set when the 64-bit result is 0. Sign is bit 63 of the 64-bit result.
- R8: The flags clear to zero on a synchronous active-high reset. After that they load at a clock edge only when opcode 6 is present, whatever its operation code.
- R9: The condition codes read the stored flags. Code 1 is Z or (S xor O). Code 2 is S xor O. Code 3 is Z. Code 4 is not Z. Code 5 is not (S xor O). Code 6 is not Z and not (S xor O). Codes 0 and 7 to F are always true.
- R10: `cond_o` is 1 for every opcode other than 2 and 7, whatever the flags and the condition code.
- R11: `wr_en_o` is 0 only for opcode 2 with a false condition. In that case `res_o` still carries `val_a_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the flags |
| op_i | input | 4 | Opcode of the current instruction |
| fn_i | input | 4 | Operation code or condition code |
| val_a_i | input | 64 | First register read value |
| val_b_i | input | 64 | Second register read value |
| val_c_i | input | 64 | Immediate value |
| res_o | output | 64 | ALU result |
| cond_o | output | 1 | Condition or branch decision |
| wr_en_o | output | 1 | Write enable for the result register |

## Verification
A flag-writing ALU instruction and a condition evaluation can meet at one clock edge. The new flags are captured at that edge, and the next instruction, a conditional jump or move, must see them rather than the older values. The bench runs each ALU operation and follows it at once with conditional jumps that probe several condition codes, so the flags are judged only through `cond_o`. It then runs non-ALU opcodes whose results are zero or negative and probes again, to show that the flags kept the values the last ALU instruction wrote.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam logic [3:0] OP_CMOV = 4'h2;
  localparam logic [3:0] OP_LDI  = 4'h3;
  localparam logic [3:0] OP_STO  = 4'h4;
  localparam logic [3:0] OP_LDM  = 4'h5;
  localparam logic [3:0] OP_ALU  = 4'h6;
  localparam logic [3:0] OP_JMP  = 4'h7;
  localparam logic [3:0] OP_CALL = 4'h8;
  localparam logic [3:0] OP_RET  = 4'h9;
  localparam logic [3:0] OP_PSH  = 4'hA;
  localparam logic [3:0] OP_POP  = 4'hB;

  localparam logic [3:0] FN_ADD = 4'h0;
  localparam logic [3:0] FN_SUB = 4'h1;
  localparam logic [3:0] FN_AND = 4'h2;
  localparam logic [3:0] FN_XOR = 4'h3;
  localparam logic [3:0] FN_MUL = 4'h4;
  localparam logic [3:0] FN_DIV = 4'h5;
  localparam logic [3:0] FN_REM = 4'h6;
  localparam logic [3:0] FN_SHL = 4'h7;
  localparam logic [3:0] FN_SHR = 4'h8;

  localparam logic [3:0] CC_LE = 4'h1;
  localparam logic [3:0] CC_LT = 4'h2;
  localparam logic [3:0] CC_EQ = 4'h3;
  localparam logic [3:0] CC_NE = 4'h4;
  localparam logic [3:0] CC_GE = 4'h5;
  localparam logic [3:0] CC_GT = 4'h6;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;
endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel
  import exu_pkg::*;
#(
  parameter int DW       = 64,
  parameter int STACK_STEP = 4
) (
  input  logic [3:0]    op,
  input  logic [3:0]    fn,
  input  logic [DW-1:0] va,
  input  logic [DW-1:0] vb,
  input  logic [DW-1:0] vc,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb,
  output logic [3:0]    alu_fn
);
  localparam logic [DW-1:0] STEP = DW'(STACK_STEP);

  // R1: operand A source
  always_comb begin
    unique case (op)
      OP_CMOV, OP_ALU:                opa = va;
      OP_LDI, OP_STO, OP_LDM, OP_JMP: opa = vc;
      OP_CALL, OP_RET, OP_PSH, OP_POP: opa = STEP;
      default:                        opa = '0;
    endcase
  end

  // R2: operand B source
  always_comb begin
    unique case (op)
      OP_STO, OP_LDM, OP_ALU, OP_CALL, OP_RET, OP_PSH, OP_POP: opb = vb;
      default: opb = '0;
    endcase
  end

  // R3: operation choice
  always_comb begin
    unique case (op)
      OP_ALU:          alu_fn = fn;
      OP_CALL, OP_PSH: alu_fn = FN_SUB;
      default:         alu_fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    fn,
  output logic [DW-1:0] res,
  output flags_t        fl
);
  localparam int SHW = $clog2(DW);

  logic [DW:0]     sum_w;
  logic [DW:0]     dif_w;
  logic [2*DW-1:0] prod_w;
  logic [SHW-1:0]  sh_amt;
  logic            a_zero;

  assign sum_w  = {1'b0, b} + {1'b0, a};
  assign dif_w  = {1'b0, b} - {1'b0, a};
  assign prod_w = {{DW{1'b0}}, b} * {{DW{1'b0}}, a};
  assign sh_amt = a[SHW-1:0];
  assign a_zero = (a == '0);

  logic ovf;
  always_comb begin
    ovf = 1'b0;
    unique case (fn)
      FN_ADD: begin res = sum_w[DW-1:0]; ovf = sum_w[DW]; end
      FN_SUB: begin res = dif_w[DW-1:0]; ovf = dif_w[DW]; end
      FN_AND: res = b & a;
      FN_XOR: res = b ^ a;
      FN_MUL: begin res = prod_w[DW-1:0]; ovf = |prod_w[2*DW-1:DW]; end
      FN_DIV: begin res = a_zero ? '1 : b / a; ovf = a_zero; end
      FN_REM: begin res = a_zero ? '1 : b % a; ovf = a_zero; end
      FN_SHL: res = b << sh_amt;
      FN_SHR: res = b >> sh_amt;
      default: res = '0;
    endcase
  end

  assign fl.z = (res == '0);
  assign fl.s = res[DW-1];
  assign fl.o = ovf;
endmodule

// File: rtl/exu_cond_eval.sv
module exu_cond_eval
  import exu_pkg::*;
(
  input  logic [3:0] op,
  input  logic [3:0] cc,
  input  flags_t     fl,
  output logic       cond
);
  logic lt, hit;
  assign lt = fl.s ^ fl.o;

  always_comb begin
    unique case (cc)
      CC_LE:   hit = fl.z | lt;
      CC_LT:   hit = lt;
      CC_EQ:   hit = fl.z;
      CC_NE:   hit = ~fl.z;
      CC_GE:   hit = ~lt;
      CC_GT:   hit = ~fl.z & ~lt;
      default: hit = 1'b1;
    endcase
  end

  assign cond = (op == OP_CMOV || op == OP_JMP) ? hit : 1'b1;
endmodule

// File: rtl/exu_stage.sv
module exu_stage
  import exu_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_i,
  input  logic [3:0]    fn_i,
  input  logic [DW-1:0] val_a_i,
  input  logic [DW-1:0] val_b_i,
  input  logic [DW-1:0] val_c_i,
  output logic [DW-1:0] res_o,
  output logic          cond_o,
  output logic          wr_en_o
);
  logic [DW-1:0] opa, opb;
  logic [3:0]    alu_fn;
  flags_t        alu_fl;
  flags_t        flags_q;

  exu_operand_sel #(.DW(DW), .STACK_STEP(4)) u_sel (
    .op(op_i), .fn(fn_i), .va(val_a_i), .vb(val_b_i), .vc(val_c_i),
    .opa(opa), .opb(opb), .alu_fn(alu_fn)
  );

  exu_alu #(.DW(DW)) u_alu (
    .a(opa), .b(opb), .fn(alu_fn), .res(res_o), .fl(alu_fl)
  );

  // R8: flags load only on the ALU opcode
  always_ff @(posedge clk) begin
    if (rst)                flags_q <= '0;
    else if (op_i == OP_ALU) flags_q <= alu_fl;
  end

  exu_cond_eval u_cond (
    .op(op_i), .cc(fn_i), .fl(flags_q), .cond(cond_o)
  );

  // R11: a failed conditional move blocks the write
  assign wr_en_o = ~((op_i == OP_CMOV) & ~cond_o);

  p_push_sub_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CALL || op_i == OP_PSH) |-> res_o == val_b_i - DW'(4));
  p_ldi_imm_r1: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LDI) |-> res_o == val_c_i);
  p_divzero_res_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ALU && (fn_i == FN_DIV || fn_i == FN_REM) && val_a_i == '0)
      |-> res_o == '1);
  p_divzero_of_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ALU && (fn_i == FN_DIV || fn_i == FN_REM) && val_a_i == '0)
      |=> flags_q.o);
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_ALU) |=> $stable(flags_q));
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ALU && res_o == '0) |=> flags_q.z);
  p_uncond_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i != OP_CMOV && op_i != OP_JMP) |-> cond_o);
  p_wren_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> (op_i == OP_CMOV && !cond_o));
endmodule

// File: tb/exu_stage_test.sv
module exu_stage_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0, fn_i = '0;
  logic [63:0] val_a_i = '0, val_b_i = '0, val_c_i = '0;
  logic [63:0] res_o;
  logic        cond_o, wr_en_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  exu_stage #(.DW(64)) uut (
    .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i),
    .val_a_i(val_a_i), .val_b_i(val_b_i), .val_c_i(val_c_i),
    .res_o(res_o), .cond_o(cond_o), .wr_en_o(wr_en_o)
  );

  task automatic drive(input logic [3:0] op, input logic [3:0] fn,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    @(negedge clk);
    op_i = op; fn_i = fn; val_a_i = a; val_b_i = b; val_c_i = c;
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // conditional jump probes the stored flags
  task automatic probe(input logic [3:0] cc, input logic exp, input string req);
    drive(4'h7, cc, 64'h0, 64'h0, 64'h0);
    chk(req, {63'b0, cond_o}, {63'b0, exp});
  endtask

  task automatic t_reset;
    probe(4'h3, 1'b0, "R8 reset Z");
    probe(4'h2, 1'b0, "R8 reset S^O");
    probe(4'h5, 1'b1, "R8 reset GE");
  endtask

  task automatic t_operands;
    drive(4'h2, 4'h0, 64'h11, 64'h22, 64'h33); chk("R1 op2 uses A", res_o, 64'h11);
    drive(4'h3, 4'h0, 64'h11, 64'h22, 64'h33); chk("R1 op3 uses C", res_o, 64'h33);
    drive(4'h4, 4'h0, 64'h11, 64'h22, 64'h33); chk("R2 op4 C+B", res_o, 64'h55);
    drive(4'h5, 4'h0, 64'h11, 64'h22, 64'h33); chk("R2 op5 C+B", res_o, 64'h55);
    drive(4'h7, 4'h0, 64'h11, 64'h22, 64'h33); chk("R2 op7 C only", res_o, 64'h33);
    drive(4'h8, 4'h0, 64'h11, 64'h100, 64'h33); chk("R3 op8 B-4", res_o, 64'hFC);
    drive(4'h9, 4'h0, 64'h11, 64'h100, 64'h33); chk("R3 op9 B+4", res_o, 64'h104);
    drive(4'hA, 4'h0, 64'h11, 64'h100, 64'h33); chk("R3 opA B-4", res_o, 64'hFC);
    drive(4'hB, 4'h0, 64'h11, 64'h100, 64'h33); chk("R3 opB B+4", res_o, 64'h104);
    drive(4'h1, 4'h1, 64'h11, 64'h22, 64'h33); chk("R1 op1 zero", res_o, 64'h0);
    drive(4'hC, 4'h4, 64'h11, 64'h22, 64'h33); chk("R1 opC zero", res_o, 64'h0);
  endtask

  task automatic t_ops;
    drive(4'h6, 4'h0, 64'h5, 64'h3, 64'h99); chk("R4 add", res_o, 64'h8);
    drive(4'h6, 4'h1, 64'h3, 64'h10, 64'h0); chk("R4 sub B-A", res_o, 64'hD);
    drive(4'h6, 4'h2, 64'hF0F0, 64'hFF00, 64'h0); chk("R4 and", res_o, 64'hF000);
    drive(4'h6, 4'h3, 64'hF0F0, 64'hFF00, 64'h0); chk("R4 xor", res_o, 64'h0FF0);
    drive(4'h6, 4'h4, 64'h5, 64'h3, 64'h0); chk("R4 mul", res_o, 64'hF);
    drive(4'h6, 4'h5, 64'h5, 64'h11, 64'h0); chk("R4 div", res_o, 64'h3);
    drive(4'h6, 4'h6, 64'h5, 64'h11, 64'h0); chk("R4 rem", res_o, 64'h2);
    drive(4'h6, 4'h7, 64'd65, 64'h1, 64'h0); chk("R4 shl low 6 bits", res_o, 64'h2);
    drive(4'h6, 4'h8, 64'd127, 64'h8000_0000_0000_0000, 64'h0); chk("R4 shr low 6 bits", res_o, 64'h1);
    drive(4'h6, 4'h9, 64'h5, 64'h3, 64'h0); chk("R4 undefined code", res_o, 64'h0);
  endtask

  task automatic t_flags;
    drive(4'h6, 4'h0, 64'h2, ONES, 64'h0); chk("R5 add wrap", res_o, 64'h1);
    probe(4'h2, 1'b1, "R5 add carry sets O");
    probe(4'h3, 1'b0, "R7 add nonzero");
    drive(4'h6, 4'h0, 64'h2, 64'h1, 64'h0);
    probe(4'h2, 1'b0, "R5 add no carry");
    probe(4'h6, 1'b1, "R9 GT");
    drive(4'h6, 4'h1, 64'h5, 64'h3, 64'h0); chk("R5 sub neg", res_o, ONES - 64'h1);
    probe(4'h2, 1'b0, "R5 borrow S and O");
    probe(4'h1, 1'b0, "R9 LE");
    probe(4'h5, 1'b1, "R9 GE");
    drive(4'h6, 4'h1, 64'h5, 64'h5, 64'h0);
    probe(4'h3, 1'b1, "R7 zero");
    probe(4'h1, 1'b1, "R9 LE zero");
    probe(4'h4, 1'b0, "R9 NE");
    probe(4'h6, 1'b0, "R9 GT zero");
    probe(4'h9, 1'b1, "R9 code 9 true");
    drive(4'h6, 4'h4, 64'h4, 64'h4000_0000_0000_0000, 64'h0);
    probe(4'h2, 1'b1, "R5 mul overflow");
    probe(4'h3, 1'b1, "R7 mul zero");
    drive(4'h6, 4'h4, 64'h2, 64'h4000_0000_0000_0000, 64'h0);
    probe(4'h2, 1'b1, "R7 sign bit");
    probe(4'h3, 1'b0, "R7 nonzero");
    drive(4'h6, 4'h7, 64'h1, ONES, 64'h0);
    probe(4'h2, 1'b1, "R5 shl no overflow");
  endtask

  task automatic t_divzero;
    drive(4'h6, 4'h5, 64'h0, 64'h7, 64'h0); chk("R6 div zero res", res_o, ONES);
    probe(4'h2, 1'b0, "R6 div zero sets O");
    drive(4'h6, 4'h6, 64'h0, 64'h7, 64'h0); chk("R6 rem zero res", res_o, ONES);
    probe(4'h2, 1'b0, "R6 rem zero sets O");
  endtask

  task automatic t_hold;
    drive(4'h5, 4'h0, 64'h0, 64'h0, 64'h0);
    drive(4'h8, 4'h0, 64'h0, 64'h0, 64'h0);
    drive(4'h3, 4'h0, 64'h0, 64'h0, 64'h0);
    probe(4'h3, 1'b0, "R8 Z held");
    probe(4'h2, 1'b0, "R8 S^O held");
    drive(4'h6, 4'hC, 64'h5, 64'h3, 64'h0);
    probe(4'h3, 1'b1, "R8 op6 undefined code loads flags");
  endtask

  task automatic t_wren;
    drive(4'h6, 4'h0, 64'h1, 64'h1, 64'h0);
    drive(4'h2, 4'h3, 64'hAB, 64'h0, 64'h0);
    chk("R11 cmov false blocks", {63'b0, wr_en_o}, 64'h0);
    chk("R11 cmov value", res_o, 64'hAB);
    drive(4'h2, 4'h4, 64'hAB, 64'h0, 64'h0);
    chk("R11 cmov true writes", {63'b0, wr_en_o}, 64'h1);
    drive(4'h7, 4'h3, 64'h0, 64'h0, 64'h0);
    chk("R11 jump false keeps enable", {63'b0, wr_en_o}, 64'h1);
    chk("R9 jump false", {63'b0, cond_o}, 64'h0);
    drive(4'h6, 4'h3, 64'h1, 64'h1, 64'h0);
    chk("R10 op6 true", {63'b0, cond_o}, 64'h1);
    drive(4'h0, 4'h3, 64'h0, 64'h0, 64'h0);
    chk("R10 op0 true", {63'b0, cond_o}, 64'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_operands();
    t_ops();
    t_flags();
    t_divzero();
    t_hold();
    t_wren();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule